// File: doc/BRIEF.md
# Sequential Signed Restoring Divider

This block divides one N-bit integer by another over several clock cycles, settling one quotient bit per cycle with the restoring long-division method. Each step shifts the next dividend bit into a partial remainder and tries to subtract the divisor. When the trial result goes negative, the old remainder is kept (restored) and the quotient bit is 0. Otherwise the difference is kept and the quotient bit is 1.

A mode input selects unsigned or two's-complement operation. In signed mode the operands are replaced by their magnitudes, the magnitudes are divided, and the signs of the quotient and remainder are corrected at the end. A zero divisor is detected before any iteration starts and is reported through a flag with a fixed result. The block takes one operation at a time. It raises a busy flag while it iterates and pulses a completion strobe when the registered result is ready.

Top module: `seq_restoring_divider`

## Requirements
- R1: A start with a zero divisor never raises `busy`. `done` and `div_zero` are high in the cycle after that start, `quotient` is all ones and `remainder` equals the dividend bit pattern, in both modes.
- R2: With `signed_mode`=0 and a nonzero divisor, `quotient` is the floor of dividend/divisor, and `remainder` is dividend minus quotient times divisor, which is always below the divisor.
- R3: A start with a nonzero divisor, sampled on clock edge k, sets `busy` from edge k until edge k+N. The result and a single-cycle `done` pulse appear after edge k+N.
- R4: A `start` while `busy` is high is ignored: the running operation completes unchanged and no second result is produced.
- R5: With `signed_mode`=1, the quotient magnitude is |dividend|/|divisor| truncated toward zero, and it is negated when exactly one operand is negative.
- R6: With `signed_mode`=1, a nonzero remainder carries the sign of the dividend, and its magnitude is |dividend| mod |divisor|.
- R7: With `signed_mode`=1, the most negative value divided by -1 gives the most negative value as quotient (bit pattern 1 followed by zeros) and a zero remainder.
- R8: After synchronous reset `busy`, `done` and `div_zero` are low, and `quotient` and `remainder` are zero.
- R9: `quotient`, `remainder` and `div_zero` hold their values between completions. A completion with a nonzero divisor clears `div_zero`.
- R10: With `signed_mode`=0, operands whose top bit is set are treated as large positive numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only while not busy |
| dividend | input | N | Dividend, sampled with an accepted start |
| divisor | input | N | Divisor, sampled with an accepted start |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse: result registers just updated |
| quotient | output | N | Quotient of the last completed operation |
| remainder | output | N | Remainder of the last completed operation |
| div_zero | output | 1 | Last completed operation had a zero divisor |

## Verification
The hardest situation to reach is a `start` that arrives while an operation is already iterating. Its operands must not leak into the running divide, and it must not leave a second result behind. The stimulus starts a division, waits a few cycles, then pulses `start` with different operands. The scoreboard then expects exactly one result, and it flags any completion that arrives with no result queued. The stimulus also issues a new operation in the cycle the previous one completes, and it covers the signed extremes (most negative over -1, and negative dividends with zero divisor).

// File: rtl/divq_pkg.sv
package divq_pkg;

  typedef enum logic {
    SGN_POS = 1'b0,
    SGN_NEG = 1'b1
  } sign_t;

  function automatic logic [63:0] mag64(input logic [63:0] v, input logic neg);
    mag64 = neg ? (~v + 64'd1) : v;
  endfunction

endpackage

// File: rtl/divq_operand_prep.sv
module divq_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0]   num_in,
  input  logic [W-1:0]   den_in,
  input  logic           use_sign,
  output logic [W-1:0]   num_mag,
  output logic [W-1:0]   den_mag,
  output divq_pkg::sign_t quo_sign,
  output divq_pkg::sign_t rem_sign
);
  import divq_pkg::*;

  logic num_neg, den_neg;

  always_comb begin
    num_neg  = use_sign & num_in[W-1];
    den_neg  = use_sign & den_in[W-1];
    num_mag  = num_neg ? (~num_in + {{(W-1){1'b0}}, 1'b1}) : num_in;
    den_mag  = den_neg ? (~den_in + {{(W-1){1'b0}}, 1'b1}) : den_in;
    quo_sign = (num_neg ^ den_neg) ? SGN_NEG : SGN_POS;
    rem_sign = num_neg ? SGN_NEG : SGN_POS;
  end

endmodule

// File: rtl/divq_step.sv
module divq_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] part_in,
  input  logic [W-1:0] shreg_in,
  input  logic [W-1:0] den,
  output logic [W-1:0] part_out,
  output logic [W-1:0] shreg_out
);

  logic [W:0] shifted;
  logic [W:0] trial;
  logic       went_neg;

  always_comb begin
    shifted  = {part_in, shreg_in[W-1]};
    trial    = shifted - {1'b0, den};
    went_neg = trial[W];
    // restore: keep the shifted remainder when the subtraction underflowed
    part_out  = went_neg ? shifted[W-1:0] : trial[W-1:0];
    shreg_out = {shreg_in[W-2:0], ~went_neg};
  end

endmodule

// File: rtl/divq_sign_fix.sv
module divq_sign_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0]    quo_mag,
  input  logic [W-1:0]    rem_mag,
  input  divq_pkg::sign_t quo_sign,
  input  divq_pkg::sign_t rem_sign,
  output logic [W-1:0]    quo_out,
  output logic [W-1:0]    rem_out
);
  import divq_pkg::*;

  always_comb begin
    quo_out = (quo_sign == SGN_NEG) ? (~quo_mag + {{(W-1){1'b0}}, 1'b1}) : quo_mag;
    rem_out = (rem_sign == SGN_NEG) ? (~rem_mag + {{(W-1){1'b0}}, 1'b1}) : rem_mag;
  end

endmodule

// File: rtl/seq_restoring_divider.sv
module seq_restoring_divider #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  input  logic         signed_mode,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder,
  output logic         div_zero
);
  import divq_pkg::*;

  localparam int CNT_W = (N > 2) ? $clog2(N) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(N - 1);

  logic [N-1:0]   num_mag, den_mag;
  sign_t          quo_sign_c, rem_sign_c;
  logic [N-1:0]   part_r, shreg_r, den_r;
  logic [N-1:0]   part_nx, shreg_nx;
  logic [N-1:0]   quo_fix, rem_fix;
  sign_t          quo_sign_r, rem_sign_r;
  logic           mode_r;
  logic [CNT_W-1:0] step_cnt;
  logic           busy_q, done_q, dz_q;
  logic [N-1:0]   quo_q, rem_q;
  logic           den_is_zero;

  assign den_is_zero = (divisor == '0);

  divq_operand_prep #(.W(N)) u_prep (
    .num_in   (dividend),
    .den_in   (divisor),
    .use_sign (signed_mode),
    .num_mag  (num_mag),
    .den_mag  (den_mag),
    .quo_sign (quo_sign_c),
    .rem_sign (rem_sign_c)
  );

  divq_step #(.W(N)) u_step (
    .part_in   (part_r),
    .shreg_in  (shreg_r),
    .den       (den_r),
    .part_out  (part_nx),
    .shreg_out (shreg_nx)
  );

  divq_sign_fix #(.W(N)) u_fix (
    .quo_mag  (shreg_nx),
    .rem_mag  (part_nx),
    .quo_sign (quo_sign_r),
    .rem_sign (rem_sign_r),
    .quo_out  (quo_fix),
    .rem_out  (rem_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      dz_q       <= 1'b0;
      quo_q      <= '0;
      rem_q      <= '0;
      part_r     <= '0;
      shreg_r    <= '0;
      den_r      <= '0;
      step_cnt   <= '0;
      mode_r     <= 1'b0;
      quo_sign_r <= SGN_POS;
      rem_sign_r <= SGN_POS;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (den_is_zero) begin
            done_q <= 1'b1;
            dz_q   <= 1'b1;
            quo_q  <= '1;
            rem_q  <= dividend;
          end else begin
            busy_q     <= 1'b1;
            step_cnt   <= '0;
            part_r     <= '0;
            shreg_r    <= num_mag;
            den_r      <= den_mag;
            mode_r     <= signed_mode;
            quo_sign_r <= quo_sign_c;
            rem_sign_r <= rem_sign_c;
          end
        end
      end else begin
        part_r   <= part_nx;
        shreg_r  <= shreg_nx;
        step_cnt <= step_cnt + 1'b1;
        if (step_cnt == LAST_STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          dz_q   <= 1'b0;
          quo_q  <= quo_fix;
          rem_q  <= rem_fix;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign div_zero  = dz_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R3
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q); // R3
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (step_cnt <= LAST_STEP)); // R3
  AST_ZERO_NO_ITER: assert property (@(posedge clk) disable iff (rst)
    (done_q && dz_q) |-> !$past(busy_q)); // R1
  AST_ZERO_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (done_q && dz_q) |-> (quo_q == '1)); // R1
  AST_UNS_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    (done_q && !dz_q && !mode_r) |-> (rem_q < den_r)); // R2
  AST_REM_FOLLOWS_DIVIDEND: assert property (@(posedge clk) disable iff (rst)
    (done_q && !dz_q && mode_r && (rem_q != '0)) |-> (rem_q[N-1] == (rem_sign_r == SGN_NEG))); // R6
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> $stable(den_r)); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> ($stable(quo_q) && $stable(rem_q) && $stable(dz_q))); // R9

endmodule

// File: tb/seq_restoring_divider_tb.sv
module seq_restoring_divider_tb;

  localparam int N = 32;

  typedef struct {
    logic [N-1:0] q;
    logic [N-1:0] r;
    logic         dz;
    int           due;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic         signed_mode = 1'b0;
  logic         busy, done, div_zero;
  logic [N-1:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  exp_t sb[$];
  logic [N-1:0] last_q, last_r;
  logic [31:0] seed = 32'h1234_5678;

  seq_restoring_divider #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend),
    .divisor(divisor), .signed_mode(signed_mode), .busy(busy),
    .done(done), .quotient(quotient), .remainder(remainder),
    .div_zero(div_zero)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [N-1:0] a, input logic [N-1:0] b, input logic sm);
    exp_t e;
    longint sa, sb2, lq, lr;
    e.dz = (b == '0);
    if (e.dz) begin
      e.q = '1;
      e.r = a;
    end else if (!sm) begin
      e.q = a / b;
      e.r = a % b;
    end else begin
      sa  = longint'($signed(a));
      sb2 = longint'($signed(b));
      lq  = sa / sb2;
      lr  = sa % sb2;
      e.q = lq[N-1:0];
      e.r = lr[N-1:0];
    end
    return e;
  endfunction

  // driver: issue one operation (caller is at a negedge with busy low)
  task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b, input logic sm, input string tag);
    exp_t e;
    e = model(a, b, sm);
    e.due = cyc + 1 + ((b == '0) ? 0 : N);
    e.tag = tag;
    sb.push_back(e);
    dividend = a; divisor = b; signed_mode = sm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (b == '0) check(busy == 1'b0, {tag, " R1 busy stays low"}, 64'(busy), 64'd0);
    else         check(busy == 1'b1, {tag, " R3 busy after start"}, 64'(busy), 64'd1);
  endtask

  task automatic wait_idle();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic run(input logic [N-1:0] a, input logic [N-1:0] b, input logic sm, input string tag);
    issue(a, b, sm, tag);
    wait_idle();
  endtask

  // monitor: compare each completion against the scoreboard head
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4 unexpected completion", 64'(quotient), 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(quotient == e.q, {e.tag, " quotient"}, 64'(quotient), 64'(e.q));
        check(remainder == e.r, {e.tag, " remainder"}, 64'(remainder), 64'(e.r));
        check(div_zero == e.dz, {e.tag, " div_zero R9"}, 64'(div_zero), 64'(e.dz));
        check(cyc == e.due, {e.tag, " R3 completion cycle"}, 64'(cyc), 64'(e.due));
        last_q = e.q;
        last_r = e.r;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(busy == 1'b0, "R8 busy", 64'(busy), 64'd0);
    check(done == 1'b0, "R8 done", 64'(done), 64'd0);
    check(div_zero == 1'b0, "R8 div_zero", 64'(div_zero), 64'd0);
    check(quotient == '0, "R8 quotient", 64'(quotient), 64'd0);
    check(remainder == '0, "R8 remainder", 64'(remainder), 64'd0);

    // R2 unsigned
    run(32'd100, 32'd7, 1'b0, "R2 100/7");
    run(32'd5, 32'd9, 1'b0, "R2 small/large");
    run(32'd12345, 32'd1, 1'b0, "R2 by one");
    run(32'd0, 32'd13, 1'b0, "R2 zero dividend");
    // R10 unsigned with top bit set
    run(32'hFFFF_FFFF, 32'd3, 1'b0, "R10 max/3");
    run(32'h8000_0000, 32'h8000_0001, 1'b0, "R10 big/bigger");
    run(32'hF000_0000, 32'hFFFF_FFF0, 1'b0, "R10 top bits");
    // R5 R6 signed
    run(-32'sd7, 32'sd2, 1'b1, "R5 R6 -7/2");
    run(32'sd7, -32'sd2, 1'b1, "R5 R6 7/-2");
    run(-32'sd7, -32'sd2, 1'b1, "R5 R6 -7/-2");
    run(-32'sd8, 32'sd2, 1'b1, "R6 exact negative");
    run(32'sd3, -32'sd10, 1'b1, "R5 small signed");
    // R7 overflow case
    run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R7 min/-1");
    // R1 zero divisor
    run(32'd77, 32'd0, 1'b0, "R1 unsigned zero divisor");
    check(div_zero == 1'b1, "R1 div_zero held", 64'(div_zero), 64'd1);
    run(32'hFFFF_FFF3, 32'd0, 1'b1, "R1 signed zero divisor");
    // R9 clear of div_zero and holding
    run(32'd50, 32'd6, 1'b0, "R9 clears flag");
    repeat (10) @(negedge clk);
    check(quotient == last_q, "R9 quotient held", 64'(quotient), 64'(last_q));
    check(remainder == last_r, "R9 remainder held", 64'(remainder), 64'(last_r));
    check(div_zero == 1'b0, "R9 div_zero low", 64'(div_zero), 64'd0);

    // R4 start while busy is ignored
    issue(32'd1000, 32'd10, 1'b0, "R4 running op");
    repeat (5) @(negedge clk);
    dividend = 32'd999; divisor = 32'd0; signed_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (N + 4) @(negedge clk);
    check(busy == 1'b0, "R4 no second run", 64'(busy), 64'd0);

    // back-to-back: issue in the cycle the previous one completes (R3)
    issue(32'd91, 32'd4, 1'b0, "R3 first of pair");
    while (!done) @(negedge clk);
    issue(-32'sd91, 32'sd4, 1'b1, "R3 second of pair");
    wait_idle();

    // pseudo-random mix of modes (R2 R5 R6)
    for (int i = 0; i < 60; i++) begin
      logic [N-1:0] a, b;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      a = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      b = (i % 3 == 0) ? (seed >> (seed[4:0])) : seed;
      run(a, b, i[0], i[0] ? "R5 R6 random signed" : "R2 random unsigned");
    end

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule